// File: doc/BRIEF.md
# Bitwise Logic Execution Unit

This block executes the bitwise logic subset of a small 8-bit RISC instruction set. There are two groups. The register-register group does AND, OR and exclusive OR between two general registers. The immediate group does AND and OR between a register and an 8-bit constant that is carried inside the instruction.

The unit holds its own general register file of 32 entries, each 8 bits wide, and an 8-bit status register. It accepts one 16-bit instruction word per clock, qualified by a valid strobe. Each accepted instruction completes in that same clock edge: the result is written back to the destination register and the status flags are updated.

Words that do not belong to this group are not executed. Instead they produce a one-cycle illegal-instruction pulse. A debug port gives a combinational read of any general register and a direct view of the status register.

Top module: `logic_exec_unit`

## Requirements
- R1: A word whose bits 15:12 are 0110 ORs register 16+w[7:4] with the constant {w[11:8], w[3:0]} and writes the result back to that same register.
- R2: A word whose bits 15:12 are 0111 ANDs register 16+w[7:4] with the constant {w[11:8], w[3:0]} and writes the result back to that same register.
- R3: A word whose bits 15:12 are 0010 combines destination register w[8:4] with source register {w[9], w[3:0]} and writes the result to the destination. When w[11:10] is 00 the operation is AND, when it is 01 it is exclusive OR, and when it is 10 it is OR.
- R4: The source and the destination may be the same register. Exclusive OR of a register with itself writes 0x00 and sets the zero flag.
- R5: The zero flag (status bit 1) is set when the result is 0x00 and cleared otherwise.
- R6: After each logic instruction the negative flag (status bit 2) equals result bit 7, the overflow flag (status bit 3) is 0, and the sign flag (status bit 4) equals the negative flag.
- R7: The carry (bit 0), half-carry (bit 5), transfer (bit 6) and interrupt-enable (bit 7) status bits are never changed by this unit.
- R8: When valid is high and the word is outside the group (this includes 0010 with w[11:10] = 11), illegal_o is high in the cycle after that edge and in no other cycle, and no register or flag changes.
- R9: While valid is low, the instruction word has no effect: no register or flag changes and illegal_o stays low.
- R10: Each instruction is committed on the clock edge where valid is high. A dependent instruction on the very next edge already sees the new value.
- R11: Synchronous active-high reset clears all 32 registers, the status register and illegal_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid on this edge |
| instr_word | input | 16 | Instruction word |
| illegal_o | output | 1 | Registered one-cycle pulse for an unsupported word |
| dbg_reg_addr | input | 5 | Register index for the debug read |
| dbg_reg_data | output | 8 | Combinational contents of the selected register |
| dbg_status | output | 8 | Current status register |

## Verification
Several behaviours are checked by the assertions on every cycle. They cover the flag invariants: overflow is clear after a write, the sign flag tracks the negative flag, and the carry, half-carry, transfer and interrupt-enable bits never move. They also check that the zero flag follows the committed result, that immediate forms only write the upper half of the file, and that an idle or illegal cycle leaves the status unchanged. Only the directed scenarios can show the rest. That includes correct operand field extraction, since the split immediate nibbles and the distant source bit are only visible through the written values. It also includes self-referencing exclusive OR, back-to-back dependency, and the fact that illegal words leave the registers they name untouched.

// File: rtl/logic_exec_pkg.sv
package logic_exec_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 8;
  localparam int REG_NUM = 32;
  localparam int ADDR_W  = $clog2(REG_NUM);

  // status register bit positions
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_N = 2;
  localparam int SB_V = 3;
  localparam int SB_S = 4;
  localparam int SB_H = 5;
  localparam int SB_T = 6;
  localparam int SB_I = 7;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2
  } logic_op_e;

  typedef struct packed {
    logic              legal;
    logic_op_e         op;
    logic              use_imm;
    logic [ADDR_W-1:0] rd;
    logic [ADDR_W-1:0] rs;
    logic [DATA_W-1:0] imm;
  } decoded_t;
endpackage

// File: rtl/lx_decoder.sv
module lx_decoder
  import logic_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output decoded_t           dec
);
  always_comb begin
    dec         = '0;
    dec.op      = OP_AND;
    dec.imm     = {word[11:8], word[3:0]};
    dec.rd      = word[8:4];
    dec.rs      = {word[9], word[3:0]};
    unique case (word[15:12])
      4'b0110, 4'b0111: begin
        dec.legal   = 1'b1;
        dec.use_imm = 1'b1;
        dec.op      = word[12] ? OP_AND : OP_OR;
        dec.rd      = {1'b1, word[7:4]};
        dec.rs      = {1'b1, word[7:4]};
      end
      4'b0010: begin
        dec.legal = (word[11:10] != 2'b11);
        unique case (word[11:10])
          2'b01:   dec.op = OP_XOR;
          2'b10:   dec.op = OP_OR;
          default: dec.op = OP_AND;
        endcase
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lx_regfile.sv
module lx_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic [AW-1:0] raddr_dbg,
  output logic [DW-1:0] rdata_dbg
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a   = mem[raddr_a];
  assign rdata_b   = mem[raddr_b];
  assign rdata_dbg = mem[raddr_dbg];
endmodule

// File: rtl/lx_alu.sv
module lx_alu
  import logic_exec_pkg::*;
(
  input  logic_op_e         op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/lx_status.sv
module lx_status
  import logic_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] sreg
);
  logic [DATA_W-1:0] sreg_nxt;

  always_comb begin
    sreg_nxt       = sreg;
    sreg_nxt[SB_Z] = (result == '0);
    sreg_nxt[SB_N] = result[DATA_W-1];
    sreg_nxt[SB_V] = 1'b0;
    sreg_nxt[SB_S] = result[DATA_W-1] ^ 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)      sreg <= '0;
    else if (upd) sreg <= sreg_nxt;
  end

  // R6: overflow cleared, sign follows negative after a write
  p_flags_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    upd |=> (!sreg[SB_V] && (sreg[SB_S] == sreg[SB_N])));

  // R7: untouched bits keep their value
  p_keep_bits_r7: assert property (@(posedge clk) disable iff (rst)
    upd |=> (sreg[SB_C] == $past(sreg[SB_C]) && sreg[SB_H] == $past(sreg[SB_H]) &&
             sreg[SB_T] == $past(sreg[SB_T]) && sreg[SB_I] == $past(sreg[SB_I])));
endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
  import logic_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               illegal_o,
  input  logic [ADDR_W-1:0]  dbg_reg_addr,
  output logic [DATA_W-1:0]  dbg_reg_data,
  output logic [DATA_W-1:0]  dbg_status
);
  decoded_t          dec;
  logic [DATA_W-1:0] rd_val, rs_val, opnd_b, alu_y, sreg_q;
  logic              commit;
  logic              illegal_q;

  lx_decoder u_dec (.word(instr_word), .dec(dec));

  assign commit = instr_valid && dec.legal;

  lx_regfile #(.DW(DATA_W), .DEPTH(REG_NUM)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (commit),
    .waddr     (dec.rd),
    .wdata     (alu_y),
    .raddr_a   (dec.rd),
    .rdata_a   (rd_val),
    .raddr_b   (dec.rs),
    .rdata_b   (rs_val),
    .raddr_dbg (dbg_reg_addr),
    .rdata_dbg (dbg_reg_data)
  );

  assign opnd_b = dec.use_imm ? dec.imm : rs_val;

  lx_alu u_alu (.op(dec.op), .a(rd_val), .b(opnd_b), .y(alu_y));

  lx_status u_sr (
    .clk    (clk),
    .rst    (rst),
    .upd    (commit),
    .result (alu_y),
    .sreg   (sreg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= instr_valid && !dec.legal;
  end

  assign illegal_o  = illegal_q;
  assign dbg_status = sreg_q;

  // R1: immediate forms only reach the upper half of the file
  p_imm_upper_r1: assert property (@(posedge clk) disable iff (rst)
    (commit && instr_word[15:13] == 3'b011) |-> dec.rd[ADDR_W-1]);

  // R5: zero flag follows the committed result
  p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> (sreg_q[SB_Z] == ($past(alu_y) == '0)));

  // R8: an unsupported word leaves flags alone and pulses illegal
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !dec.legal) |=> (illegal_o && $stable(sreg_q)));

  // R9: idle cycle changes nothing
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!illegal_o && $stable(sreg_q)));
endmodule

// File: tb/logic_exec_unit_tb.sv
module logic_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        illegal_o;
  logic [4:0]  dbg_reg_addr = '0;
  logic [7:0]  dbg_reg_data;
  logic [7:0]  dbg_status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  logic_exec_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .illegal_o(illegal_o), .dbg_reg_addr(dbg_reg_addr),
    .dbg_reg_data(dbg_reg_data), .dbg_status(dbg_status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int idx, input logic [7:0] exp);
    dbg_reg_addr = idx[4:0];
    #1;
    chk(req, dbg_reg_data, exp);
  endtask

  // one instruction with valid high for one edge, ends at the following negedge
  task automatic issue(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr_word  = w;
    instr_valid = v;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R11 status", dbg_status, 8'h00);
    chk("R11 illegal", {7'b0, illegal_o}, 8'h00);
    chk_reg("R11 r0", 0, 8'h00);
    chk_reg("R11 r16", 16, 8'h00);
    chk_reg("R11 r31", 31, 8'h00);
  endtask

  task automatic t_immediate();
    issue(16'h6A05, 1'b1);              // ORI r16,0xA5
    chk_reg("R1 ori r16", 16, 8'hA5);
    chk("R6 ori flags", dbg_status, 8'h14);
    issue(16'h700F, 1'b1);              // ANDI r16,0x0F
    chk_reg("R2 andi r16", 16, 8'h05);
    chk("R5 andi flags", dbg_status, 8'h00);
    issue(16'h68F0, 1'b1);              // ORI r31,0x80
    chk_reg("R1 ori r31", 31, 8'h80);
    chk("R6 negative sign", dbg_status, 8'h14);
    issue(16'h631C, 1'b1);              // ORI r17,0x3C
    chk_reg("R1 ori r17", 17, 8'h3C);
    chk_reg("R1 r1 untouched", 1, 8'h00);
  endtask

  task automatic t_regreg();
    issue(16'h2A00, 1'b1);              // OR r0,r16
    chk_reg("R3 or r0", 0, 8'h05);
    issue(16'h2B4F, 1'b1);              // OR r20,r31
    chk_reg("R3 or r20", 20, 8'h80);
    chk("R6 or flags", dbg_status, 8'h14);
    issue(16'h2341, 1'b1);              // AND r20,r17
    chk_reg("R3 and r20", 20, 8'h00);
    chk("R5 zero set", dbg_status, 8'h02);
    issue(16'h2510, 1'b1);              // EOR r17,r0
    chk_reg("R3 eor r17", 17, 8'h39);
    chk("R5 zero clear", dbg_status, 8'h00);
    chk_reg("R3 source kept", 0, 8'h05);
  endtask

  task automatic t_self();
    issue(16'h27FF, 1'b1);              // EOR r31,r31
    chk_reg("R4 self eor", 31, 8'h00);
    chk("R4 zero flag", dbg_status, 8'h02);
    chk("R7 other bits", dbg_status & 8'hE1, 8'h00);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    instr_word = 16'h2C00; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R8 pulse high", {7'b0, illegal_o}, 8'h01);
    chk_reg("R8 r0 kept", 0, 8'h05);
    chk("R8 status kept", dbg_status, 8'h02);
    @(negedge clk);
    chk("R8 pulse ends", {7'b0, illegal_o}, 8'h00);
    issue(16'h8000, 1'b1);
    chk("R8 other word", {7'b0, illegal_o}, 8'h01);
  endtask

  task automatic t_idle();
    issue(16'h6FFF, 1'b0);              // would be ORI r31,0xFF
    chk_reg("R9 r31 kept", 31, 8'h00);
    chk("R9 no illegal", {7'b0, illegal_o}, 8'h00);
    chk("R9 status kept", dbg_status, 8'h02);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    instr_word = 16'h6021; instr_valid = 1'b1;   // ORI r18,0x01
    @(negedge clk);
    instr_word = 16'h2B21;                       // OR r18,r17
    @(negedge clk);
    instr_valid = 1'b0;
    chk_reg("R10 back to back", 18, 8'h39);
    chk("R10 flags", dbg_status, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_immediate();
    t_regreg();
    t_self();
    t_illegal();
    t_idle();
    t_b2b();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule